// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steers a multicycle processor datapath from a small control store instead of a hardwired state machine. A microinstruction address register selects one 22-bit control word per clock. Each word carries the datapath settings for that step (program counter update, memory access, register write, ALU operand selection, ALU function) and a 2-bit sequencing action. The action either steps to the next word, jumps back to the fetch word at address 0, or jumps through one of two lookup tables. The first table is indexed by the opcode and function field. The second table separates loads from stores.

The block sees the held opcode and function field of the current instruction and two ALU flags, zero and negative. It emits the same control signals a hardwired unit for this datapath would emit. It has no storage beyond the microinstruction address. All control words are fixed in a case table.

Top module: `microseq_ctrl`

## Requirements
- R1: While rst_n is low, and on the first cycle after rst_n is released, the outputs show the fetch step. Asserting rst_n in the middle of an instruction returns the outputs to the fetch step at once.
- R2: Fetch step: mem_read=1, ir_write=1, inst_data=0, alu_src_x=0, alu_src_y=0 (constant four), fn_class=2 (arithmetic), add_sub=0, pc_src=3 (ALU result), pc_write=1. The decode step follows: alu_src_y=3 (immediate times four), fn_class=2, alu_src_x=0, no writes. In every step, any output not listed for it is 0.
- R3: After decode, the step is chosen from the opcode. Opcode 0 uses the function field: 0x20 add, 0x22 sub, 0x2A slt, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x08 jr, 0x0C syscall. The other opcodes are: 0x0F lui, 0x08 addi, 0x0A slti, 0x0C andi, 0x0D ori, 0x0E xori, 0x23 load, 0x2B store, 0x02 j, 0x03 jal, 0x04 beq, 0x05 bne, 0x01 bltz.
- R4: An ALU instruction takes two steps. The first step has alu_src_x=1 and alu_src_y=1 (y register) or 2 (immediate). It sets add_sub=1 for sub, slt and slti. It sets fn_class to 0 (upper immediate), 1 (set-less), 2 (arithmetic) or 3 (logic), and logic_fn to 0 AND, 1 OR, 2 XOR or 3 NOR. The second step has reg_write=1 and reg_in_src=1 (z register). Its reg_dst is 1 (rd) for register-form instructions and 0 (rt) for immediate-form instructions.
- R5: Load and store first run an address step: alu_src_x=1, alu_src_y=2, fn_class=2. The second table then picks the path. A load runs inst_data=1 with mem_read=1, then reg_write=1 with reg_dst=0 and reg_in_src=0 (data register). A store runs inst_data=1 with mem_write=1.
- R6: A branch step drives alu_src_x=1, alu_src_y=1, add_sub=1, fn_class=2 and pc_src=2 (z register). pc_write equals alu_zero for beq, the inverse of alu_zero for bne, and alu_neg for bltz.
- R7: j drives pc_write=1, jump_sel=0, pc_src=0. jr drives pc_write=1, pc_src=1 (x register). syscall drives pc_write=1, jump_sel=1 (handler address), pc_src=0. jal is the same as j and also drives reg_write=1, reg_dst=2 (register 31) and reg_in_src=2 (PC).
- R8: An opcode or function code not listed in R3 leads to a single trap step. This step drives trap=1, pc_write=1, jump_sel=1 and pc_src=0.
- R9: Every instruction returns to the fetch step once its last step is done. ALU instructions and stores take 4 steps, loads take 5, and jumps, branches and the trap take 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the held instruction |
| funct | input | 6 | Function field of the held instruction |
| alu_zero | input | 1 | ALU result is zero |
| alu_neg | input | 1 | ALU result sign bit |
| pc_write | output | 1 | Load the program counter |
| jump_sel | output | 1 | Jump address: 0 target field, 1 handler |
| pc_src | output | 2 | PC source: 0 jump address, 1 x, 2 z, 3 ALU |
| inst_data | output | 1 | Memory address: 0 PC, 1 z register |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| ir_write | output | 1 | Load the instruction register |
| reg_write | output | 1 | Register file write |
| reg_dst | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| reg_in_src | output | 2 | Write data: 0 data reg, 1 z reg, 2 PC |
| alu_src_x | output | 1 | ALU x operand: 0 PC, 1 x register |
| alu_src_y | output | 2 | ALU y operand: 0 four, 1 y, 2 imm, 3 imm*4 |
| add_sub | output | 1 | 0 add, 1 subtract |
| logic_fn | output | 2 | 0 AND, 1 OR, 2 XOR, 3 NOR |
| fn_class | output | 2 | 0 upper imm, 1 set-less, 2 arithmetic, 3 logic |
| trap | output | 1 | Unknown-instruction trap step |

## Verification
In the branch step, the conditional program counter write and the return-to-fetch jump happen in the same cycle. The write depends on the flags, while the return must not. The bench runs each branch kind once with its condition true and once with it false. It checks that pc_write follows the selected flag in that step and that the fetch word appears on the next cycle in both cases. The jal step also combines two functions, a PC update and the link register write. Its single expected word checks both halves together.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UPC_W = 6;
    localparam int OP_W  = 6;
    localparam int FN_W  = 6;

    typedef logic [UPC_W-1:0] upc_t;
    typedef logic [OP_W-1:0]  op_t;
    typedef logic [FN_W-1:0]  fn_t;

    typedef enum logic [1:0] {SEQ_INC, SEQ_D1, SEQ_D2, SEQ_FETCH} seq_e;
    typedef enum logic [1:0] {PW_NONE, PW_ALWAYS, PW_COND, PW_TRAP} pwr_e;
    typedef enum logic [1:0] {CM_NONE, CM_FETCH, CM_LOAD, CM_STORE} cmem_e;

    // 22-bit microinstruction
    typedef struct packed {
        logic       jsel;
        logic [1:0] psrc;
        pwr_e       pwr;
        cmem_e      cm;
        logic       rwe;
        logic [1:0] rdst;
        logic [1:0] rsrc;
        logic       asx;
        logic [1:0] asy;
        logic       asub;
        logic [1:0] lfn;
        logic [1:0] fcls;
        seq_e       seq;
    } uinstr_t;

    typedef struct packed {
        upc_t upc;
    } seq_st_t;

    // control store layout; ALU routines occupy even/odd pairs
    localparam upc_t A_FETCH = 6'd0,  A_DEC  = 6'd1,  A_LUI  = 6'd2,  A_ADD  = 6'd4;
    localparam upc_t A_SUB   = 6'd6,  A_SLT  = 6'd8,  A_ADDI = 6'd10, A_SLTI = 6'd12;
    localparam upc_t A_AND   = 6'd14, A_OR   = 6'd16, A_XOR  = 6'd18, A_NOR  = 6'd20;
    localparam upc_t A_ANDI  = 6'd22, A_ORI  = 6'd24, A_XORI = 6'd26, A_MEM  = 6'd28;
    localparam upc_t A_LD1   = 6'd29, A_LD2  = 6'd30, A_ST1  = 6'd31, A_J    = 6'd32;
    localparam upc_t A_JR    = 6'd33, A_BR   = 6'd34, A_JAL  = 6'd35, A_SYS  = 6'd36;
    localparam upc_t A_TRAP  = 6'd37;

    localparam op_t OP_RFORM = 6'h00, OP_BLTZ = 6'h01, OP_J    = 6'h02, OP_JAL  = 6'h03;
    localparam op_t OP_BEQ   = 6'h04, OP_BNE  = 6'h05, OP_ADDI = 6'h08, OP_SLTI = 6'h0A;
    localparam op_t OP_ANDI  = 6'h0C, OP_ORI  = 6'h0D, OP_XORI = 6'h0E, OP_LUI  = 6'h0F;
    localparam op_t OP_LD    = 6'h23, OP_ST   = 6'h2B;

    localparam fn_t FN_JR  = 6'h08, FN_SYS = 6'h0C, FN_ADD = 6'h20, FN_SUB = 6'h22;
    localparam fn_t FN_AND = 6'h24, FN_OR  = 6'h25, FN_XOR = 6'h26, FN_NOR = 6'h27;
    localparam fn_t FN_SLT = 6'h2A;

    localparam logic [1:0] PS_JADDR = 2'd0, PS_XREG = 2'd1, PS_ZREG = 2'd2, PS_ALU = 2'd3;
    localparam logic [1:0] RD_RT = 2'd0, RD_RD = 2'd1, RD_LINK = 2'd2;
    localparam logic [1:0] RS_DATA = 2'd0, RS_ZREG = 2'd1, RS_PC = 2'd2;
    localparam logic [1:0] AY_FOUR = 2'd0, AY_YREG = 2'd1, AY_IMM = 2'd2, AY_IMM4 = 2'd3;
    localparam logic [1:0] FC_UPPER = 2'd0, FC_SLT = 2'd1, FC_ARITH = 2'd2, FC_LOGIC = 2'd3;
    localparam logic [1:0] LF_AND = 2'd0, LF_OR = 2'd1, LF_XOR = 2'd2, LF_NOR = 2'd3;

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  upc_t    addr,
    output uinstr_t word
);

    function automatic uinstr_t f_calc(logic [1:0] y, logic s, logic [1:0] lf, logic [1:0] fc);
        uinstr_t u;
        u      = '0;
        u.asx  = 1'b1;
        u.asy  = y;
        u.asub = s;
        u.lfn  = lf;
        u.fcls = fc;
        u.seq  = SEQ_INC;
        return u;
    endfunction

    function automatic uinstr_t f_wb(logic [1:0] dst);
        uinstr_t u;
        u      = '0;
        u.rwe  = 1'b1;
        u.rdst = dst;
        u.rsrc = RS_ZREG;
        u.seq  = SEQ_FETCH;
        return u;
    endfunction

    logic in_alu_wb;
    logic wb_to_rd;

    assign in_alu_wb = (addr > A_LUI) && (addr < A_MEM) && addr[0];
    assign wb_to_rd  = ((addr > A_ADD) && (addr < A_ADDI)) || ((addr > A_AND) && (addr < A_ANDI));

    always_comb begin
        word     = '0;
        word.seq = SEQ_FETCH;
        if (in_alu_wb) begin
            word = f_wb(wb_to_rd ? RD_RD : RD_RT);
        end else begin
            case (addr)
                A_FETCH: begin
                    word.cm   = CM_FETCH;
                    word.asy  = AY_FOUR;
                    word.fcls = FC_ARITH;
                    word.psrc = PS_ALU;
                    word.pwr  = PW_ALWAYS;
                    word.seq  = SEQ_INC;
                end
                A_DEC: begin
                    word.asy  = AY_IMM4;
                    word.fcls = FC_ARITH;
                    word.seq  = SEQ_D1;
                end
                A_LUI:  word = f_calc(AY_IMM,  1'b0, LF_AND, FC_UPPER);
                A_ADD:  word = f_calc(AY_YREG, 1'b0, LF_AND, FC_ARITH);
                A_SUB:  word = f_calc(AY_YREG, 1'b1, LF_AND, FC_ARITH);
                A_SLT:  word = f_calc(AY_YREG, 1'b1, LF_AND, FC_SLT);
                A_ADDI: word = f_calc(AY_IMM,  1'b0, LF_AND, FC_ARITH);
                A_SLTI: word = f_calc(AY_IMM,  1'b1, LF_AND, FC_SLT);
                A_AND:  word = f_calc(AY_YREG, 1'b0, LF_AND, FC_LOGIC);
                A_OR:   word = f_calc(AY_YREG, 1'b0, LF_OR,  FC_LOGIC);
                A_XOR:  word = f_calc(AY_YREG, 1'b0, LF_XOR, FC_LOGIC);
                A_NOR:  word = f_calc(AY_YREG, 1'b0, LF_NOR, FC_LOGIC);
                A_ANDI: word = f_calc(AY_IMM,  1'b0, LF_AND, FC_LOGIC);
                A_ORI:  word = f_calc(AY_IMM,  1'b0, LF_OR,  FC_LOGIC);
                A_XORI: word = f_calc(AY_IMM,  1'b0, LF_XOR, FC_LOGIC);
                A_MEM: begin
                    word     = f_calc(AY_IMM, 1'b0, LF_AND, FC_ARITH);
                    word.seq = SEQ_D2;
                end
                A_LD1: begin
                    word.cm  = CM_LOAD;
                    word.seq = SEQ_INC;
                end
                A_LD2: begin
                    word.rwe  = 1'b1;
                    word.rdst = RD_RT;
                    word.rsrc = RS_DATA;
                end
                A_ST1: word.cm = CM_STORE;
                A_J: begin
                    word.pwr  = PW_ALWAYS;
                    word.psrc = PS_JADDR;
                end
                A_JR: begin
                    word.pwr  = PW_ALWAYS;
                    word.psrc = PS_XREG;
                end
                A_BR: begin
                    word      = f_calc(AY_YREG, 1'b1, LF_AND, FC_ARITH);
                    word.pwr  = PW_COND;
                    word.psrc = PS_ZREG;
                    word.seq  = SEQ_FETCH;
                end
                A_JAL: begin
                    word.pwr  = PW_ALWAYS;
                    word.psrc = PS_JADDR;
                    word.rwe  = 1'b1;
                    word.rdst = RD_LINK;
                    word.rsrc = RS_PC;
                end
                A_SYS: begin
                    word.pwr  = PW_ALWAYS;
                    word.jsel = 1'b1;
                end
                A_TRAP: begin
                    word.pwr  = PW_TRAP;
                    word.jsel = 1'b1;
                end
                default: word.seq = SEQ_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
(
    input  op_t  op,
    input  fn_t  fn,
    output upc_t d1_addr,
    output upc_t d2_addr
);

    always_comb begin
        d1_addr = A_TRAP;
        case (op)
            OP_RFORM: begin
                case (fn)
                    FN_ADD:  d1_addr = A_ADD;
                    FN_SUB:  d1_addr = A_SUB;
                    FN_SLT:  d1_addr = A_SLT;
                    FN_AND:  d1_addr = A_AND;
                    FN_OR:   d1_addr = A_OR;
                    FN_XOR:  d1_addr = A_XOR;
                    FN_NOR:  d1_addr = A_NOR;
                    FN_JR:   d1_addr = A_JR;
                    FN_SYS:  d1_addr = A_SYS;
                    default: d1_addr = A_TRAP;
                endcase
            end
            OP_LUI:  d1_addr = A_LUI;
            OP_ADDI: d1_addr = A_ADDI;
            OP_SLTI: d1_addr = A_SLTI;
            OP_ANDI: d1_addr = A_ANDI;
            OP_ORI:  d1_addr = A_ORI;
            OP_XORI: d1_addr = A_XORI;
            OP_LD,
            OP_ST:   d1_addr = A_MEM;
            OP_J:    d1_addr = A_J;
            OP_JAL:  d1_addr = A_JAL;
            OP_BEQ,
            OP_BNE,
            OP_BLTZ: d1_addr = A_BR;
            default: d1_addr = A_TRAP;
        endcase
    end

    // second table: load/store split
    assign d2_addr = (op == OP_ST) ? A_ST1 : A_LD1;

endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  uinstr_t    word,
    input  op_t        op,
    input  logic       alu_zero,
    input  logic       alu_neg,
    output logic       pc_write,
    output logic       jump_sel,
    output logic [1:0] pc_src,
    output logic       inst_data,
    output logic       mem_read,
    output logic       mem_write,
    output logic       ir_write,
    output logic       reg_write,
    output logic [1:0] reg_dst,
    output logic [1:0] reg_in_src,
    output logic       alu_src_x,
    output logic [1:0] alu_src_y,
    output logic       add_sub,
    output logic [1:0] logic_fn,
    output logic [1:0] fn_class,
    output logic       trap
);

    logic br_cond;

    always_comb begin
        case (op)
            OP_BEQ:  br_cond = alu_zero;
            OP_BNE:  br_cond = ~alu_zero;
            OP_BLTZ: br_cond = alu_neg;
            default: br_cond = 1'b0;
        endcase
    end

    always_comb begin
        pc_write = 1'b0;
        case (word.pwr)
            PW_ALWAYS: pc_write = 1'b1;
            PW_COND:   pc_write = br_cond;
            PW_TRAP:   pc_write = 1'b1;
            default:   pc_write = 1'b0;
        endcase
    end

    assign trap       = (word.pwr == PW_TRAP);
    assign jump_sel   = word.jsel;
    assign pc_src     = word.psrc;
    assign inst_data  = (word.cm == CM_LOAD) || (word.cm == CM_STORE);
    assign mem_read   = (word.cm == CM_FETCH) || (word.cm == CM_LOAD);
    assign mem_write  = (word.cm == CM_STORE);
    assign ir_write   = (word.cm == CM_FETCH);
    assign reg_write  = word.rwe;
    assign reg_dst    = word.rdst;
    assign reg_in_src = word.rsrc;
    assign alu_src_x  = word.asx;
    assign alu_src_y  = word.asy;
    assign add_sub    = word.asub;
    assign logic_fn   = word.lfn;
    assign fn_class   = word.fcls;

endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
    import useq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       alu_zero,
    input  logic       alu_neg,
    output logic       pc_write,
    output logic       jump_sel,
    output logic [1:0] pc_src,
    output logic       inst_data,
    output logic       mem_read,
    output logic       mem_write,
    output logic       ir_write,
    output logic       reg_write,
    output logic [1:0] reg_dst,
    output logic [1:0] reg_in_src,
    output logic       alu_src_x,
    output logic [1:0] alu_src_y,
    output logic       add_sub,
    output logic [1:0] logic_fn,
    output logic [1:0] fn_class,
    output logic       trap
);

    seq_st_t st_d, st_q;
    uinstr_t mi;
    upc_t    d1_addr, d2_addr;

    useq_store u_store (
        .addr (st_q.upc),
        .word (mi)
    );

    useq_dispatch u_dispatch (
        .op      (opcode),
        .fn      (funct),
        .d1_addr (d1_addr),
        .d2_addr (d2_addr)
    );

    useq_decode u_decode (
        .word       (mi),
        .op         (opcode),
        .alu_zero   (alu_zero),
        .alu_neg    (alu_neg),
        .pc_write   (pc_write),
        .jump_sel   (jump_sel),
        .pc_src     (pc_src),
        .inst_data  (inst_data),
        .mem_read   (mem_read),
        .mem_write  (mem_write),
        .ir_write   (ir_write),
        .reg_write  (reg_write),
        .reg_dst    (reg_dst),
        .reg_in_src (reg_in_src),
        .alu_src_x  (alu_src_x),
        .alu_src_y  (alu_src_y),
        .add_sub    (add_sub),
        .logic_fn   (logic_fn),
        .fn_class   (fn_class),
        .trap       (trap)
    );

    always_comb begin
        st_d = st_q;
        case (mi.seq)
            SEQ_INC:   st_d.upc = st_q.upc + upc_t'(1);
            SEQ_D1:    st_d.upc = d1_addr;
            SEQ_D2:    st_d.upc = d2_addr;
            default:   st_d.upc = A_FETCH;
        endcase
    end

    // R1: asynchronous reset to the fetch word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upc == A_FETCH) |=> (st_q.upc == A_DEC));

    // R3
    decode_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upc == A_DEC) |=> (st_q.upc != A_DEC && st_q.upc != A_FETCH));

    // R4
    regwrite_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_write |=> (st_q.upc == A_FETCH));

    // R5
    mem_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upc == A_MEM) |=> (st_q.upc == A_LD1 || st_q.upc == A_ST1));

    // R8
    trap_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (st_q.upc == A_FETCH && ir_write));

endmodule

// File: tb/microseq_ctrl_bench.sv
module microseq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0, funct = '0;
    logic       alu_zero = 1'b0, alu_neg = 1'b0;
    logic       pc_write, jump_sel, inst_data, mem_read, mem_write, ir_write, reg_write;
    logic       alu_src_x, add_sub, trap;
    logic [1:0] pc_src, reg_dst, reg_in_src, alu_src_y, logic_fn, fn_class;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    microseq_ctrl u_microseq_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
        .alu_zero(alu_zero), .alu_neg(alu_neg), .pc_write(pc_write),
        .jump_sel(jump_sel), .pc_src(pc_src), .inst_data(inst_data),
        .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
        .reg_write(reg_write), .reg_dst(reg_dst), .reg_in_src(reg_in_src),
        .alu_src_x(alu_src_x), .alu_src_y(alu_src_y), .add_sub(add_sub),
        .logic_fn(logic_fn), .fn_class(fn_class), .trap(trap)
    );

    wire [21:0] obs = {pc_write, jump_sel, pc_src, inst_data, mem_read, mem_write, ir_write,
                       reg_write, reg_dst, reg_in_src, alu_src_x, alu_src_y, add_sub,
                       logic_fn, fn_class, trap};

    function automatic logic [21:0] cw(bit pcw, bit js, bit [1:0] ps, bit idat, bit mr, bit mw,
                                       bit irw, bit rw, bit [1:0] rd, bit [1:0] ris, bit ax,
                                       bit [1:0] ay, bit sb, bit [1:0] lf, bit [1:0] fc, bit tr);
        return {pcw, js, ps, idat, mr, mw, irw, rw, rd, ris, ax, ay, sb, lf, fc, tr};
    endfunction

    function automatic logic [21:0] w_fetch();
        return cw(1, 0, 3, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0);
    endfunction
    function automatic logic [21:0] w_dec();
        return cw(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 2, 0);
    endfunction
    function automatic logic [21:0] w_alu(bit [1:0] ay, bit sb, bit [1:0] lf, bit [1:0] fc);
        return cw(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ay, sb, lf, fc, 0);
    endfunction
    function automatic logic [21:0] w_wb(bit [1:0] d);
        return cw(0, 0, 0, 0, 0, 0, 0, 1, d, 1, 0, 0, 0, 0, 0, 0);
    endfunction
    function automatic logic [21:0] w_br(bit c);
        return cw(c, 0, 2, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 2, 0);
    endfunction
    function automatic logic [21:0] w_trap();
        return cw(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endfunction

    task automatic check(bit ok, string tag, int step, logic [21:0] got, logic [21:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s step %0d: got %h expected %h", tag, step, got, exp);
        end
    endtask

    // reference model: expected control word per step, one instruction
    task automatic exec(logic [5:0] o, logic [5:0] f, bit z, bit n, string tag);
        logic [21:0] q[$];
        q.push_back(w_fetch());
        q.push_back(w_dec());
        case (o)
            6'h00: case (f)
                6'h20: begin q.push_back(w_alu(1, 0, 0, 2)); q.push_back(w_wb(1)); end
                6'h22: begin q.push_back(w_alu(1, 1, 0, 2)); q.push_back(w_wb(1)); end
                6'h2A: begin q.push_back(w_alu(1, 1, 0, 1)); q.push_back(w_wb(1)); end
                6'h24: begin q.push_back(w_alu(1, 0, 0, 3)); q.push_back(w_wb(1)); end
                6'h25: begin q.push_back(w_alu(1, 0, 1, 3)); q.push_back(w_wb(1)); end
                6'h26: begin q.push_back(w_alu(1, 0, 2, 3)); q.push_back(w_wb(1)); end
                6'h27: begin q.push_back(w_alu(1, 0, 3, 3)); q.push_back(w_wb(1)); end
                6'h08: q.push_back(cw(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
                6'h0C: q.push_back(cw(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
                default: q.push_back(w_trap());
            endcase
            6'h0F: begin q.push_back(w_alu(2, 0, 0, 0)); q.push_back(w_wb(0)); end
            6'h08: begin q.push_back(w_alu(2, 0, 0, 2)); q.push_back(w_wb(0)); end
            6'h0A: begin q.push_back(w_alu(2, 1, 0, 1)); q.push_back(w_wb(0)); end
            6'h0C: begin q.push_back(w_alu(2, 0, 0, 3)); q.push_back(w_wb(0)); end
            6'h0D: begin q.push_back(w_alu(2, 0, 1, 3)); q.push_back(w_wb(0)); end
            6'h0E: begin q.push_back(w_alu(2, 0, 2, 3)); q.push_back(w_wb(0)); end
            6'h23: begin
                q.push_back(w_alu(2, 0, 0, 2));
                q.push_back(cw(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
                q.push_back(cw(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
            end
            6'h2B: begin
                q.push_back(w_alu(2, 0, 0, 2));
                q.push_back(cw(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
            end
            6'h02: q.push_back(cw(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
            6'h03: q.push_back(cw(1, 0, 0, 0, 0, 0, 0, 1, 2, 2, 0, 0, 0, 0, 0, 0));
            6'h04: q.push_back(w_br(z));
            6'h05: q.push_back(w_br(!z));
            6'h01: q.push_back(w_br(n));
            default: q.push_back(w_trap());
        endcase
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            if (i == 0) begin
                opcode = o; funct = f; alu_zero = z; alu_neg = n;
            end
            #1;
            // step 0 also confirms the previous instruction returned to fetch (R9)
            check(obs == q[i], (i == 0) ? {tag, "/R2/R9"} : tag, i, obs, q[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: held in reset shows the fetch word
        repeat (2) @(negedge clk);
        #1 check(obs == w_fetch(), "R1", 0, obs, w_fetch());
        @(posedge clk);
        #2 rst_n = 1'b1;

        // R3 R4 register-form ALU
        exec(6'h00, 6'h20, 0, 0, "R3/R4 add");
        exec(6'h00, 6'h22, 0, 0, "R4 sub");
        exec(6'h00, 6'h2A, 0, 0, "R4 slt");
        exec(6'h00, 6'h24, 0, 0, "R4 and");
        exec(6'h00, 6'h25, 0, 0, "R4 or");
        exec(6'h00, 6'h26, 0, 0, "R4 xor");
        exec(6'h00, 6'h27, 0, 0, "R4 nor");
        // R4 immediate-form ALU
        exec(6'h0F, 6'h3F, 0, 0, "R4 lui");
        exec(6'h08, 6'h00, 0, 0, "R4 addi");
        exec(6'h0A, 6'h00, 0, 0, "R4 slti");
        exec(6'h0C, 6'h00, 0, 0, "R4 andi");
        exec(6'h0D, 6'h00, 0, 0, "R4 ori");
        exec(6'h0E, 6'h00, 0, 0, "R4 xori");
        // R5 memory split
        exec(6'h23, 6'h00, 0, 0, "R5 load");
        exec(6'h2B, 6'h00, 0, 0, "R5 store");
        exec(6'h23, 6'h2B, 1, 1, "R5 load2");
        // R6 branches, condition true and false
        exec(6'h04, 6'h00, 1, 0, "R6 beq taken");
        exec(6'h04, 6'h00, 0, 1, "R6 beq not");
        exec(6'h05, 6'h00, 0, 0, "R6 bne taken");
        exec(6'h05, 6'h00, 1, 0, "R6 bne not");
        exec(6'h01, 6'h00, 0, 1, "R6 bltz taken");
        exec(6'h01, 6'h00, 1, 0, "R6 bltz not");
        // R7 jumps
        exec(6'h02, 6'h00, 0, 0, "R7 j");
        exec(6'h00, 6'h08, 0, 0, "R7 jr");
        exec(6'h00, 6'h0C, 0, 0, "R7 syscall");
        exec(6'h03, 6'h00, 0, 0, "R7 jal");
        // R8 unknown codes
        exec(6'h3F, 6'h00, 0, 0, "R8 bad op");
        exec(6'h00, 6'h01, 0, 0, "R8 bad funct");
        exec(6'h00, 6'h20, 0, 0, "R8 after trap");

        // R1: reset in the middle of an instruction
        @(negedge clk);
        opcode = 6'h23;
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1 check(obs == w_fetch(), "R1 mid", 0, obs, w_fetch());
        @(posedge clk);
        #2 rst_n = 1'b1;
        exec(6'h2B, 6'h00, 0, 0, "R1/R5 after reset");

        // R9 final return to fetch
        @(negedge clk);
        #1 check(obs == w_fetch(), "R9", 0, obs, w_fetch());

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule